// File: doc/BRIEF.md
# Dual-Rail Ripple-Carry Adder with Weak-Indication Completion

This block adds two WIDTH-bit operands and a carry-in. Every operand bit, the carry-in, every sum bit and the carry-out is carried on a pair of wires: a true rail and a false rail. A raised true rail means 1, a raised false rail means 0, and two low rails mean "empty". The block is written as synchronous RTL that models an asynchronous ripple adder. Each full-adder stage registers its result one clock after its incoming carry becomes valid, so the carry ripples through the stages one per clock.

A four-phase handshake frames each addition. The requester presents valid operands and raises `req`. The stages then evaluate in ripple order, and `done` rises once the result is complete. The requester then lowers `req` and empties its inputs. All outputs return to empty together, and `done` falls after that. Completion is judged only from the WIDTH sum outputs and the final carry-out. No internal carry is inspected, because no stage can present a valid sum or carry before its own carry-in is valid. A separate flag reports any input pair that has both rails high.

Top module: `dr_ripple_adder`

## Requirements
- R1: A synchronous active-high reset, applied at any time, leaves every sum and carry-out rail low, `done` low and `err` low after the next clock edge.
- R2: With the encoding true-rail-high = 1, false-rail-high = 0, the completed result {cout, sum} decodes to a + b + cin, and each output pair has exactly one rail high.
- R3: Stage i (bit i of the sum, counting from 0) becomes valid exactly i+1 clock edges after the first edge at which `req` is high with valid inputs. Before that edge its rails are both low. The carry-out becomes valid at the same edge as stage WIDTH-1.
- R4: `done` rises exactly one edge after the sum and carry-out are all valid, which is edge WIDTH+1. It is never high while any observed output is still empty.
- R5: At the first edge with `req` low, every sum and carry-out rail goes low.
- R6: `done` stays high at the edge where the outputs empty. It falls one edge later, once every observed output has been seen empty.
- R7: If `req` is lowered before the last stage has fired, the outputs return to empty and `done` never rises for that operation.
- R8: An input pair (operand bit or carry-in) with both rails high sets `err` one edge later. The stage receiving that pair does not fire, so it and every later stage stay empty and `done` stays low. `err` clears one edge after the inputs become legal.
- R9: No sum or carry-out pair ever has both rails high.
- R10: While `req` stays high, an output rail that has gone high stays high, even if the operand inputs change after completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one ripple step per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Four-phase request: high to evaluate, low to return to empty |
| a_t | input | WIDTH | Operand A, true rails |
| a_f | input | WIDTH | Operand A, false rails |
| b_t | input | WIDTH | Operand B, true rails |
| b_f | input | WIDTH | Operand B, false rails |
| cin_t | input | 1 | Carry-in, true rail |
| cin_f | input | 1 | Carry-in, false rail |
| sum_t | output | WIDTH | Sum, true rails |
| sum_f | output | WIDTH | Sum, false rails |
| cout_t | output | 1 | Carry-out, true rail |
| cout_f | output | 1 | Carry-out, false rail |
| done | output | 1 | Completion: high when the result is valid, low after return to empty |
| err | output | 1 | Registered flag for an input pair with both rails high |

## Verification
Two functions can act in the same cycle: the last stage firing and the return to empty. Both fall on one edge when `req` is dropped after exactly WIDTH-1 edges of evaluation, which is one edge short of the carry-out becoming valid. At that edge the clear must win. The bench judges this by watching `done` at every negedge for several cycles and then confirming that every rail is low. A second overlap is between the illegal-input flag and a partial ripple. A doubled pair in the middle of operand A must raise `err` while the lower stages still fill in, and the bench checks the mask of valid sum bits against the position of the bad pair.

// File: rtl/dr_pkg.sv
package dr_pkg;
  // one dual-rail wire pair
  typedef struct packed {
    logic t;
    logic f;
  } rail_t;

  // exactly one rail high: a data value is present
  function automatic logic rail_valid(input rail_t r);
    return r.t ^ r.f;
  endfunction

  // both rails high: never a legal code
  function automatic logic rail_bad(input rail_t r);
    return r.t & r.f;
  endfunction
endpackage

// File: rtl/dr_stage.sv
module dr_stage
  import dr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  req,
  input  rail_t opa,
  input  rail_t opb,
  input  rail_t cy_in,
  output rail_t s_out,
  output rail_t cy_out
);
  logic fire;
  logic s_val;
  logic c_val;

  // a stage evaluates only once its carry-in is valid
  assign fire  = req && rail_valid(opa) && rail_valid(opb) && rail_valid(cy_in)
                 && !rail_valid(s_out);
  assign s_val = opa.t ^ opb.t ^ cy_in.t;
  assign c_val = (opa.t & opb.t) | (opa.t & cy_in.t) | (opb.t & cy_in.t);

  always_ff @(posedge clk) begin
    if (rst || !req) begin
      s_out  <= '0;
      cy_out <= '0;
    end else if (fire) begin
      s_out  <= '{t: s_val, f: !s_val};
      cy_out <= '{t: c_val, f: !c_val};
    end
  end
endmodule

// File: rtl/dr_completion.sv
module dr_completion #(
  parameter int N = 9
) (
  input  logic [N-1:0] rt,
  input  logic [N-1:0] rf,
  output logic         all_valid,
  output logic         all_empty
);
  logic [N-1:0] v;
  logic [N-1:0] e;

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign v[i] = rt[i] ^ rf[i];
    assign e[i] = !(rt[i] | rf[i]);
  end

  // reduction trees, one leaf per observed output pair
  assign all_valid = &v;
  assign all_empty = &e;
endmodule

// File: rtl/dr_illegal.sv
module dr_illegal #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_t,
  input  logic [WIDTH-1:0] a_f,
  input  logic [WIDTH-1:0] b_t,
  input  logic [WIDTH-1:0] b_f,
  input  logic             cin_t,
  input  logic             cin_f,
  output logic             bad
);
  assign bad = (|(a_t & a_f)) | (|(b_t & b_f)) | (cin_t & cin_f);
endmodule

// File: rtl/dr_ripple_adder.sv
module dr_ripple_adder
  import dr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [WIDTH-1:0] a_t,
  input  logic [WIDTH-1:0] a_f,
  input  logic [WIDTH-1:0] b_t,
  input  logic [WIDTH-1:0] b_f,
  input  logic             cin_t,
  input  logic             cin_f,
  output logic [WIDTH-1:0] sum_t,
  output logic [WIDTH-1:0] sum_f,
  output logic             cout_t,
  output logic             cout_f,
  output logic             done,
  output logic             err
);
  localparam int NOBS = WIDTH + 1;

  rail_t carry [WIDTH+1];
  rail_t sums  [WIDTH];
  logic  all_valid;
  logic  all_empty;
  logic  bad_in;

  assign carry[0] = '{t: cin_t, f: cin_f};

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    dr_stage u_stage (
      .clk    (clk),
      .rst    (rst),
      .req    (req),
      .opa    ('{t: a_t[i], f: a_f[i]}),
      .opb    ('{t: b_t[i], f: b_f[i]}),
      .cy_in  (carry[i]),
      .s_out  (sums[i]),
      .cy_out (carry[i+1])
    );
    assign sum_t[i] = sums[i].t;
    assign sum_f[i] = sums[i].f;
  end

  assign cout_t = carry[WIDTH].t;
  assign cout_f = carry[WIDTH].f;

  // weak indication: sums plus final carry only
  dr_completion #(.N(NOBS)) u_cd (
    .rt        ({cout_t, sum_t}),
    .rf        ({cout_f, sum_f}),
    .all_valid (all_valid),
    .all_empty (all_empty)
  );

  dr_illegal #(.WIDTH(WIDTH)) u_bad (
    .a_t   (a_t),
    .a_f   (a_f),
    .b_t   (b_t),
    .b_f   (b_f),
    .cin_t (cin_t),
    .cin_f (cin_f),
    .bad   (bad_in)
  );

  // done behaves like a C-element: set on all valid, clear on all empty
  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      err <= bad_in;
      if (all_valid)      done <= 1'b1;
      else if (all_empty) done <= 1'b0;
    end
  end
endmodule

// File: rtl/dr_ripple_adder_chk.sv
module dr_ripple_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req,
  input logic [WIDTH-1:0] a_t,
  input logic [WIDTH-1:0] a_f,
  input logic [WIDTH-1:0] b_t,
  input logic [WIDTH-1:0] b_f,
  input logic             cin_t,
  input logic             cin_f,
  input logic [WIDTH-1:0] sum_t,
  input logic [WIDTH-1:0] sum_f,
  input logic             cout_t,
  input logic             cout_f,
  input logic             done,
  input logic             err
);
  logic obs_valid;
  logic obs_empty;
  logic in_bad;

  assign obs_valid = (&(sum_t ^ sum_f)) && (cout_t ^ cout_f);
  assign obs_empty = (sum_t == '0) && (sum_f == '0) && !cout_t && !cout_f;
  assign in_bad    = (|(a_t & a_f)) || (|(b_t & b_f)) || (cin_t && cin_f);

  p_rail_legal_r9: assert property (@(posedge clk) disable iff (rst)
    ((sum_t & sum_f) == '0) && !(cout_t && cout_f));

  p_done_after_valid_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(obs_valid));

  p_clear_on_release_r5: assert property (@(posedge clk) disable iff (rst)
    !req |=> obs_empty);

  p_done_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(obs_empty));

  p_rails_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (req && $past(req)) |->
      (((sum_t & $past(sum_t)) == $past(sum_t)) &&
       ((sum_f & $past(sum_f)) == $past(sum_f))));

  p_err_flag_r8: assert property (@(posedge clk) disable iff (rst)
    in_bad |=> err);
endmodule

bind dr_ripple_adder dr_ripple_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_dr_ripple_adder.sv
module tb_dr_ripple_adder;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         req;
  logic [W-1:0] a_t, a_f, b_t, b_f;
  logic         cin_t, cin_f;
  logic [W-1:0] sum_t, sum_f;
  logic         cout_t, cout_f, done, err;

  int checks = 0;
  int errors = 0;

  always #10 clk = !clk;

  dr_ripple_adder #(.WIDTH(W)) dut (.*);

  // {cin, a, b}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'h00, 8'h00}, {1'b0, 8'hff, 8'h01}, {1'b1, 8'hff, 8'hff},
    {1'b0, 8'haa, 8'h55}, {1'b1, 8'h55, 8'h55}, {1'b0, 8'h80, 8'h80},
    {1'b0, 8'h0f, 8'hf1}, {1'b1, 8'h12, 8'h34}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    a_t = a; a_f = ~a; b_t = b; b_f = ~b; cin_t = c; cin_f = !c;
  endtask

  task automatic idle();
    req = 1'b0; a_t = '0; a_f = '0; b_t = '0; b_f = '0; cin_t = 1'b0; cin_f = 1'b0;
  endtask

  task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    logic [W:0] exp;
    exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    drive(a, b, c); req = 1'b1;
    @(negedge clk);
    chk(((sum_t[0] ^ sum_f[0]) == 1'b1) && (sum_t[1] | sum_f[1]) == 1'b0, "R3 first stage only",
        {sum_t[1:0], sum_f[1:0]}, 32'h0);
    repeat (W-2) @(negedge clk);
    chk(!(sum_t[W-1] | sum_f[W-1]) && !cout_t && !cout_f && !done, "R3 last stage empty at W-1",
        {done, cout_t, cout_f, sum_t[W-1], sum_f[W-1]}, 32'h0);
    @(negedge clk);
    chk(((sum_t ^ sum_f) == '1) && (cout_t ^ cout_f) && !done, "R4 valid but done not yet",
        {done, cout_t ^ cout_f}, 32'h1);
    @(negedge clk);
    chk(done, "R4 done at W+1", done, 1);
    chk({cout_t, sum_t} == exp && {cout_f, sum_f} == ~exp, "R2 sum value", {cout_t, sum_t}, exp);
    idle();
    @(negedge clk);
    chk(sum_t == '0 && sum_f == '0 && !cout_t && !cout_f, "R5 empty after release",
        {cout_t, cout_f, sum_t, sum_f}, 0);
    chk(done, "R6 done held one edge", done, 1);
    @(negedge clk);
    chk(!done, "R6 done falls", done, 0);
  endtask

  initial begin
    rst = 1'b1; idle();
    repeat (3) @(negedge clk);
    chk(sum_t == '0 && sum_f == '0 && !cout_t && !cout_f && !done && !err, "R1 reset state",
        {done, err, cout_t, cout_f, sum_t, sum_f}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 8; i++) run_add(VEC[i][15:8], VEC[i][7:0], VEC[i][16]);

    // R7: release one edge before the final stage fires
    drive(8'hff, 8'h01, 1'b1); req = 1'b1;
    repeat (W-1) @(negedge clk);
    idle();
    for (int k = 0; k < W + 2; k++) begin
      @(negedge clk);
      chk(!done, "R7 done stays low on early release", done, 0);
    end
    chk(sum_t == '0 && sum_f == '0 && !cout_t && !cout_f, "R7 outputs empty",
        {cout_t, cout_f, sum_t, sum_f}, 0);

    // R10: operands change after completion, outputs hold
    drive(8'h3c, 8'h0f, 1'b0); req = 1'b1;
    repeat (W+1) @(negedge clk);
    drive(8'hff, 8'hff, 1'b1);
    repeat (2) @(negedge clk);
    chk({cout_t, sum_t} == 9'h04b && done, "R10 result held", {cout_t, sum_t}, 9'h04b);
    idle();
    repeat (3) @(negedge clk);

    // R8: bit 3 of A has both rails high
    drive(8'h00, 8'h00, 1'b0); a_t[3] = 1'b1; a_f[3] = 1'b1; req = 1'b1;
    @(negedge clk);
    chk(err, "R8 err raised", err, 1);
    repeat (W+1) @(negedge clk);
    chk((sum_t | sum_f) == 8'h07 && !done, "R8 ripple stops at bad pair", {done, sum_t | sum_f}, 8'h07);
    idle();
    @(negedge clk);
    chk(!err, "R8 err clears", err, 0);

    // R1: reset in the middle of an evaluation
    repeat (2) @(negedge clk);
    drive(8'h11, 8'h22, 1'b0); req = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(sum_t == '0 && sum_f == '0 && !done && !err, "R1 mid-operation reset",
        {done, err, sum_t, sum_f}, 0);
    rst = 1'b0; idle();
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule